// File: doc/BRIEF.md
# GPIO Port Controller with Atomic Set/Clear

This block controls a bank of general-purpose pins (eight by default) through a narrow, byte-wide register bus. Software chooses a drive mode for each pin and writes an output latch. It can also flip individual output bits without a read-modify-write, through a write-only command register that takes two bits per pin. Raw pin levels pass through a chain of flip-flops before software can read them, so asynchronous inputs settle before they are used.

Each pin has its own output-value and output-enable signals, which go to a pad ring outside the block. The mode field selects one of four drive styles: input only, push-pull, open-drain, or pass-through of an alternate source that a neighbouring function supplies. All bus accesses are single-byte. Register lanes scale with the pin count. With eight pins, the mode register occupies offsets 0x00–0x01, the synchronized input register is at 0x02, the output latch is at 0x03, and the command register occupies 0x04–0x05.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every mode field is 00 and every output latch bit is 0. `pin_oe` and `pin_out` are all zero, and the synchronizer stages hold 0.
- R2: The mode register gives pin n the 2-bit field at bits [2n+1:2n], stored low byte at offset 0x00 and high byte at 0x01. A byte write changes only the four fields in that byte, and a read returns the stored byte.
- R3: The output latch at offset 0x03 holds one bit per pin (bit n = pin n). It can be written and read back.
- R4: Offset 0x02 returns the pin levels after SYNC_STAGES flip-flops. A pin change made just before rising edge 1 appears on a read issued at edge SYNC_STAGES+1 and not earlier. Writes to 0x02 change no register.
- R5: The command register at 0x04 (pins 0–3) and 0x05 (pins 4–7) gives pin n the 2-bit field at bits [2(n mod 4)+1 : 2(n mod 4)] of its byte. Code 01 sets the latch bit, 10 clears it, and 00 or 11 leaves it. Pins that are not commanded keep their value in the same write.
- R6: Reads of the command register offsets and of unmapped offsets (0x06 and up) return 0x00.
- R7: Mode 00 (input only) gives `pin_oe`=0 and `pin_out`=0.
- R8: Mode 01 (push-pull) gives `pin_oe`=1 and `pin_out` = latch bit.
- R9: Mode 10 (open-drain) gives `pin_out`=0 and `pin_oe` = inverse of the latch bit.
- R10: Mode 11 (alternate) passes `alt_val_in` to `pin_out` and `alt_en_in` to `pin_oe`.
- R11: `bus_rd_data` updates on the rising edge at which `bus_rd_en` is high and holds its value otherwise. Reads have a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe, one byte per cycle |
| bus_wr_data | input | 8 | Write data byte |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 8 | Registered read data |
| pin_in | input | PIN_COUNT | Raw asynchronous pin levels |
| alt_val_in | input | PIN_COUNT | Alternate-source output values |
| alt_en_in | input | PIN_COUNT | Alternate-source output enables |
| pin_out | output | PIN_COUNT | Per-pin output value to the pad |
| pin_oe | output | PIN_COUNT | Per-pin output enable to the pad |

## Verification
Register writes take effect at the rising edge that samples the strobe. The pad signals follow combinationally, so the bench reads them at the next falling edge. Read data appears after the edge that samples `bus_rd_en`. The scoreboard therefore pops each expected byte at the falling edge that follows that edge. For the input path, the bench changes the pins and then issues back-to-back reads. The first SYNC_STAGES reads must still show the old level and the next read must show the new one, which fixes the lag to the exact cycle.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;

  typedef enum logic [1:0] {
    PM_INPUT     = 2'b00,
    PM_PUSHPULL  = 2'b01,
    PM_OPENDRAIN = 2'b10,
    PM_ALT       = 2'b11
  } pin_mode_e;

  // Returns {oe, value} for one pin.
  function automatic logic [1:0] pin_drive(input pin_mode_e mode,
                                           input logic latch_bit,
                                           input logic alt_val,
                                           input logic alt_en);
    logic [1:0] r;
    unique case (mode)
      PM_INPUT:     r = 2'b00;
      PM_PUSHPULL:  r = {1'b1, latch_bit};
      PM_OPENDRAIN: r = {~latch_bit, 1'b0};
      default:      r = {alt_en, alt_val};
    endcase
    return r;
  endfunction

  function automatic logic cmd_is_set(input logic [1:0] code);
    return code == 2'b01;
  endfunction

  function automatic logic cmd_is_clr(input logic [1:0] code);
    return code == 2'b10;
  endfunction

endpackage

// File: rtl/gpio_sync_chain.sv
`timescale 1ns/1ps
module gpio_sync_chain #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_drive.sv
`timescale 1ns/1ps
module gpio_pin_drive
  import gpio_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       latch_bit,
  input  logic       alt_val,
  input  logic       alt_en,
  output logic       drv_val,
  output logic       drv_en
);
  logic [1:0] drv;

  always_comb drv = pin_drive(pin_mode_e'(mode), latch_bit, alt_val, alt_en);

  assign drv_en  = drv[1];
  assign drv_val = drv[0];
endmodule

// File: rtl/gpio_csr_bank.sv
`timescale 1ns/1ps
module gpio_csr_bank
  import gpio_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr_en,
  input  logic [7:0]             wr_data,
  input  logic                   rd_en,
  output logic [7:0]             rd_data,
  input  logic [PIN_COUNT-1:0]   in_sync,
  output logic [2*PIN_COUNT-1:0] mode_q,
  output logic [PIN_COUNT-1:0]   out_q,
  output logic                   wr_mode_hit,
  output logic                   wr_out_hit,
  output logic                   wr_sc_hit,
  output logic [PIN_COUNT-1:0]   set_mask,
  output logic [PIN_COUNT-1:0]   clr_mask
);
  localparam int MODE_BYTES = (2*PIN_COUNT + 7) / 8;
  localparam int IO_BYTES   = (PIN_COUNT + 7) / 8;
  localparam int IN_BASE    = MODE_BYTES;
  localparam int OUT_BASE   = IN_BASE + IO_BYTES;
  localparam int SC_BASE    = OUT_BASE + IO_BYTES;
  localparam int SC_END     = SC_BASE + MODE_BYTES;

  logic [MODE_BYTES*8-1:0] mode_pad;
  logic [IO_BYTES*8-1:0]   out_pad;
  logic [IO_BYTES*8-1:0]   in_pad;
  int                      a_int;
  logic                    rd_mode_hit, rd_in_hit, rd_out_hit;
  logic [7:0]              rd_next;

  assign a_int    = int'(addr);
  assign mode_pad = (MODE_BYTES*8)'(mode_q);
  assign out_pad  = (IO_BYTES*8)'(out_q);
  assign in_pad   = (IO_BYTES*8)'(in_sync);

  assign wr_mode_hit = wr_en && (a_int < MODE_BYTES);
  assign wr_out_hit  = wr_en && (a_int >= OUT_BASE) && (a_int < SC_BASE);
  assign wr_sc_hit   = wr_en && (a_int >= SC_BASE) && (a_int < SC_END);
  assign rd_mode_hit = a_int < MODE_BYTES;
  assign rd_in_hit   = (a_int >= IN_BASE) && (a_int < OUT_BASE);
  assign rd_out_hit  = (a_int >= OUT_BASE) && (a_int < SC_BASE);

  // Command decode: one field per pin in the addressed byte.
  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    for (int p = 0; p < PIN_COUNT; p++) begin
      if (wr_sc_hit && (p / 4 == a_int - SC_BASE)) begin
        set_mask[p] = cmd_is_set(wr_data[(p % 4)*2 +: 2]);
        clr_mask[p] = cmd_is_clr(wr_data[(p % 4)*2 +: 2]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else begin
      for (int p = 0; p < PIN_COUNT; p++) begin
        if (wr_mode_hit && (p / 4 == a_int))
          mode_q[2*p +: 2] <= wr_data[(p % 4)*2 +: 2];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      for (int p = 0; p < PIN_COUNT; p++) begin
        if (wr_out_hit && (p / 8 == a_int - OUT_BASE))
          out_q[p] <= wr_data[p % 8];
        else if (set_mask[p])
          out_q[p] <= 1'b1;
        else if (clr_mask[p])
          out_q[p] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_next = 8'h00;
    if (rd_mode_hit)
      rd_next = mode_pad[a_int*8 +: 8];
    else if (rd_in_hit)
      rd_next = in_pad[(a_int - IN_BASE)*8 +: 8];
    else if (rd_out_hit)
      rd_next = out_pad[(a_int - OUT_BASE)*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
module gpio_port_ctrl #(
  parameter int PIN_COUNT   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr_en,
  input  logic [7:0]           bus_wr_data,
  input  logic                 bus_rd_en,
  output logic [7:0]           bus_rd_data,
  input  logic [PIN_COUNT-1:0] pin_in,
  input  logic [PIN_COUNT-1:0] alt_val_in,
  input  logic [PIN_COUNT-1:0] alt_en_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe
);
  logic [PIN_COUNT-1:0]   in_sync;
  logic [2*PIN_COUNT-1:0] mode_q;
  logic [PIN_COUNT-1:0]   out_q;
  logic                   wr_mode_hit, wr_out_hit, wr_sc_hit;
  logic [PIN_COUNT-1:0]   set_mask, clr_mask;

  gpio_sync_chain #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d (pin_in),
    .q (in_sync)
  );

  gpio_csr_bank #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_csr (
    .clk (clk),
    .rst_n (rst_n),
    .addr (bus_addr),
    .wr_en (bus_wr_en),
    .wr_data (bus_wr_data),
    .rd_en (bus_rd_en),
    .rd_data (bus_rd_data),
    .in_sync (in_sync),
    .mode_q (mode_q),
    .out_q (out_q),
    .wr_mode_hit (wr_mode_hit),
    .wr_out_hit (wr_out_hit),
    .wr_sc_hit (wr_sc_hit),
    .set_mask (set_mask),
    .clr_mask (clr_mask)
  );

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    gpio_pin_drive u_drv (
      .mode (mode_q[2*p +: 2]),
      .latch_bit (out_q[p]),
      .alt_val (alt_val_in[p]),
      .alt_en (alt_en_in[p]),
      .drv_val (pin_out[p]),
      .drv_en (pin_oe[p])
    );
  end
endmodule

// File: rtl/gpio_port_ctrl_checker.sv
`timescale 1ns/1ps
module gpio_port_ctrl_checker #(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W    = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_rd_en,
  input logic [7:0]             bus_rd_data,
  input logic [2*PIN_COUNT-1:0] mode_q,
  input logic [PIN_COUNT-1:0]   out_q,
  input logic [PIN_COUNT-1:0]   pin_out,
  input logic [PIN_COUNT-1:0]   pin_oe,
  input logic [PIN_COUNT-1:0]   alt_val_in,
  input logic [PIN_COUNT-1:0]   alt_en_in,
  input logic                   wr_sc_hit,
  input logic                   wr_out_hit,
  input logic [PIN_COUNT-1:0]   set_mask,
  input logic [PIN_COUNT-1:0]   clr_mask
);
  localparam int MODE_BYTES = (2*PIN_COUNT + 7) / 8;
  localparam int IO_BYTES   = (PIN_COUNT + 7) / 8;
  localparam int SC_BASE    = MODE_BYTES + 2*IO_BYTES;

  AST_SC_MASKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask & clr_mask) == '0);                                          // R5
  AST_SC_SETS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sc_hit |=> ((out_q & $past(set_mask)) == $past(set_mask)));         // R5
  AST_SC_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sc_hit |=> ((out_q & $past(clr_mask)) == '0));                      // R5
  AST_SC_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sc_hit && !wr_out_hit) |=>
      (((out_q ^ $past(out_q)) & ~$past(set_mask | clr_mask)) == '0));     // R5
  AST_RD_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && int'(bus_addr) >= SC_BASE) |=> bus_rd_data == 8'h00);    // R6
  AST_RD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> $stable(bus_rd_data));                                  // R11

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_chk
    AST_MODE_INPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[2*p +: 2] == 2'b00 |-> (!pin_oe[p] && !pin_out[p]));          // R7
    AST_MODE_PUSHPULL: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[2*p +: 2] == 2'b01 |-> (pin_oe[p] && pin_out[p] == out_q[p])); // R8
    AST_MODE_OPENDRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[2*p +: 2] == 2'b10 |-> (!pin_out[p] && pin_oe[p] != out_q[p])); // R9
    AST_MODE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[2*p +: 2] == 2'b11 |->
        (pin_oe[p] == alt_en_in[p] && pin_out[p] == alt_val_in[p]));       // R10
  end
endmodule

bind gpio_port_ctrl gpio_port_ctrl_checker #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .bus_addr (bus_addr),
  .bus_rd_en (bus_rd_en),
  .bus_rd_data (bus_rd_data),
  .mode_q (mode_q),
  .out_q (out_q),
  .pin_out (pin_out),
  .pin_oe (pin_oe),
  .alt_val_in (alt_val_in),
  .alt_en_in (alt_en_in),
  .wr_sc_hit (wr_sc_hit),
  .wr_out_hit (wr_out_hit),
  .set_mask (set_mask),
  .clr_mask (clr_mask)
);

// File: tb/tb_gpio_port_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_port_ctrl;
  localparam int N      = 8;
  localparam int STAGES = 2;
  localparam int AW     = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr_en = 1'b0;
  logic [7:0]    bus_wr_data = '0;
  logic          bus_rd_en = 1'b0;
  logic [7:0]    bus_rd_data;
  logic [N-1:0]  pin_in = '0, alt_val_in = '0, alt_en_in = '0;
  logic [N-1:0]  pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  // Bench model of the registers.
  logic [2*N-1:0] m_mode = '0;
  logic [N-1:0]   m_out  = '0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl #(.PIN_COUNT(N), .SYNC_STAGES(STAGES), .ADDR_W(AW)) dut (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr_en (bus_wr_en),
    .bus_wr_data (bus_wr_data), .bus_rd_en (bus_rd_en), .bus_rd_data (bus_rd_data),
    .pin_in (pin_in), .alt_val_in (alt_val_in), .alt_en_in (alt_en_in),
    .pin_out (pin_out), .pin_oe (pin_oe)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Driver tasks: called at a falling edge, return at the next falling edge.
  task automatic bus_write(input int a, input logic [7:0] d);
    bus_addr = AW'(a); bus_wr_data = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input int a, input logic [7:0] exp, input string req);
    bus_addr = AW'(a); bus_rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  // Monitor: compare read data one falling edge after the sampling edge.
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd_en === 1'b1) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R11: got %h expected no read data", bus_rd_data);
        end else begin
          check(tag_q.pop_front(), 32'(bus_rd_data), 32'(exp_q.pop_front()));
        end
      end
    end
  end

  // Expected pad drive from mode codes: 00 in, 01 push-pull, 10 open-drain, 11 alternate.
  task automatic check_pads(input string req);
    logic [N-1:0] eo, ev;
    for (int p = 0; p < N; p++) begin
      case (m_mode[2*p +: 2])
        2'b00: begin eo[p] = 0; ev[p] = 0; end
        2'b01: begin eo[p] = 1; ev[p] = m_out[p]; end
        2'b10: begin eo[p] = !m_out[p]; ev[p] = 0; end
        default: begin eo[p] = alt_en_in[p]; ev[p] = alt_val_in[p]; end
      endcase
    end
    check({req, " oe"}, 32'(pin_oe), 32'(eo));
    check({req, " out"}, 32'(pin_out), 32'(ev));
  endtask

  task automatic sc_write(input int byte_idx, input logic [7:0] d);
    for (int k = 0; k < 4; k++) begin
      if (d[2*k +: 2] == 2'b01) m_out[byte_idx*4 + k] = 1'b1;
      if (d[2*k +: 2] == 2'b10) m_out[byte_idx*4 + k] = 1'b0;
    end
    bus_write(4 + byte_idx, d);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 oe", 32'(pin_oe), 0);
    check("R1 out", 32'(pin_out), 0);
    bus_read(0, 8'h00, "R1 mode lo");
    bus_read(1, 8'h00, "R1 mode hi");
    bus_read(3, 8'h00, "R1 latch");
    bus_read(2, 8'h00, "R1 input");

    // R2: byte-lane writes to the mode register
    bus_write(0, 8'h1B); m_mode[7:0] = 8'h1B;
    bus_read(0, 8'h1B, "R2 lo");
    bus_read(1, 8'h00, "R2 hi untouched");
    bus_write(1, 8'hE4); m_mode[15:8] = 8'hE4;
    bus_read(1, 8'hE4, "R2 hi");
    bus_read(0, 8'h1B, "R2 lo kept");

    // R3: output latch
    bus_write(3, 8'h3C); m_out = 8'h3C;
    bus_read(3, 8'h3C, "R3 latch");

    // R7..R10: every mode present across the pins
    alt_val_in = 8'h55; alt_en_in = 8'h0F;
    #1 check_pads("R7 R8 R9 R10 a");
    @(negedge clk);
    bus_write(3, 8'hC3); m_out = 8'hC3;
    alt_val_in = 8'hAA; alt_en_in = 8'hF0;
    #1 check_pads("R7 R8 R9 R10 b");
    @(negedge clk);
    bus_write(3, 8'h3C); m_out = 8'h3C;

    // R5: set/clear commands
    sc_write(0, 8'hC9);
    bus_read(3, 8'h3D, "R5 low byte");
    check("R5 model", 32'(m_out), 32'h3D);
    sc_write(1, 8'h1E);
    bus_read(3, 8'h6D, "R5 high byte");
    sc_write(0, 8'h00);
    sc_write(1, 8'hFF);
    bus_read(3, 8'h6D, "R5 no-op codes");
    check_pads("R8 R9 after set/clear");

    // R6: command and unmapped offsets read zero
    bus_read(4, 8'h00, "R6 cmd lo");
    bus_read(5, 8'h00, "R6 cmd hi");
    bus_read(6, 8'h00, "R6 unmapped 6");
    bus_read(15, 8'h00, "R6 unmapped 15");

    // R4: writes to input register ignored; exact synchronizer lag
    bus_write(2, 8'hFF);
    bus_read(2, 8'h00, "R4 write ignored input");
    bus_read(3, 8'h6D, "R4 write ignored latch");
    pin_in = 8'h96;
    for (int s = 0; s < STAGES; s++) bus_read(2, 8'h00, "R4 before lag");
    bus_read(2, 8'h96, "R4 after lag");

    // R11: read data holds without a read strobe
    @(negedge clk);
    held = bus_rd_data;
    pin_in = 8'h11;
    bus_write(3, 8'h00);
    repeat (4) @(negedge clk);
    check("R11 hold", 32'(bus_rd_data), 32'(held));

    repeat (3) @(negedge clk);
    check("R11 queue drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule